// File: doc/BRIEF.md
# Windowed Thermal Trend Predictor

This block keeps one core's short thermal history and, on each management tick, turns a fresh sample into a one-step-ahead estimate. The estimate starts from the current sample. A history term is added to it: the mean of the recent samples minus a programmable bias, so a core that ran cool over the recent past is predicted lower and one that ran hot is predicted higher. A slope term is added as well: half the change from the previous sample. Only a sliding window of the latest samples takes part in the history term. Older samples leave the window and have no further effect.

A mode input selects what is tracked. In absolute mode the sample is the core temperature. In balance mode the sample is the core temperature minus a chip-wide average supplied from outside, so the same arithmetic then predicts the core's deviation from the average. One instance serves one core. A migration controller elsewhere reads `pred` when `pred_vld` pulses. All values are signed fixed point with 8 fraction bits (°C × 256).

Top module: `thermal_trend_predictor`

## Requirements
- R1: After reset, `pred_vld` is 0, `not_ready` is 1 and `pred` is 0.
- R2: In absolute mode (`bal_mode`=0) the sample is `core_temp` sign-extended to 17 bits. In balance mode (`bal_mode`=1) it is the exact 17-bit difference `core_temp - chip_avg`.
- R3: For a valid strobe with sample x, previous sample p, window sum S and bias H, `pred` = x + floor(S/DEPTH) − H + floor((x − p)/2). The result is exact in 20 signed bits for all 16-bit inputs.
- R4: The window sum S covers exactly the DEPTH samples taken before the current strobe. The current sample is not part of it, and a sample drops out DEPTH strobes after it entered.
- R5: The window mean is rounded toward negative infinity, also for negative sums.
- R6: The slope term is the sample difference shifted right arithmetically by SLOPE_SHIFT (1 by default), which rounds toward negative infinity.
- R7: `not_ready` is 1 while fewer than DEPTH samples are held. A strobe produces `pred_vld` only if DEPTH samples were held before it.
- R8: `pred_vld` is a one-cycle pulse in the second cycle after the cycle in which `smp_stb` was high. `pred` changes only together with that pulse and holds its value otherwise.
- R9: A strobe whose `bal_mode` differs from that of the previous strobe discards the history. That sample becomes the first of a new window, no pulse follows it, and `not_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe per management tick; samples the inputs below |
| bal_mode | input | 1 | 0: absolute temperature, 1: deviation from chip average |
| core_temp | input | 16 | Core temperature, signed Q8.8 °C |
| chip_avg | input | 16 | Chip average temperature, signed Q8.8 °C (balance mode) |
| hist_bias | input | 16 | History bias H, signed Q8.8 |
| pred | output | 20 | Predicted value, signed Q12.8 |
| pred_vld | output | 1 | One-cycle pulse when `pred` is new |
| not_ready | output | 1 | Window not yet filled |

## Verification
The properties assume that `core_temp`, `chip_avg`, `hist_bias` and `bal_mode` are valid in every cycle in which `smp_stb` is high, and that the strobe is synchronous to `clk`. They impose no minimum spacing between strobes. The stimulus changes all inputs at the falling edge and spaces strobes three cycles apart, so each pulse can be checked isolated. The window fill, the hold cycle and the mode restarts are all observed at the ports. Sample sequences cover ramps, a bias sweep around a constant, pseudo-random signed values in both modes, the 17-bit extremes of the balance difference, and a single spike that must leave the window after exactly DEPTH strobes.

// File: rtl/thermpred_pkg.sv
package thermpred_pkg;
  typedef enum logic {SRC_ABS = 1'b0, SRC_DELTA = 1'b1} src_mode_e;

  // Reciprocal multiplier for a divide by n: ceil(2^s / n)
  function automatic longint recip_mult(input int n, input int s);
    return ((64'sd1 <<< s) + longint'(n) - 64'sd1) / longint'(n);
  endfunction
endpackage

// File: rtl/tp_sample_select.sv
module tp_sample_select
  import thermpred_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic                 mode,
  input  logic signed [W-1:0]  core_temp,
  input  logic signed [W-1:0]  chip_avg,
  output logic signed [SW-1:0] sample,
  output logic                 restart
);
  src_mode_e mode_e, mode_q;
  logic      seen_q;

  function automatic logic signed [SW-1:0] pick(input src_mode_e m,
                                                input logic signed [W-1:0] t,
                                                input logic signed [W-1:0] a);
    return (m == SRC_DELTA) ? (SW'(t) - SW'(a)) : SW'(t);
  endfunction

  assign mode_e  = src_mode_e'(mode);
  assign sample  = pick(mode_e, core_temp, chip_avg);
  assign restart = stb && seen_q && (mode_e != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRC_ABS;
      seen_q <= 1'b0;
    end else if (stb) begin
      mode_q <= mode_e;
      seen_q <= 1'b1;
    end
  end

  // R2: the balance sample plus the average gives back the core reading
  always_comb begin
    if (rst_n && mode_e == SRC_DELTA)
      p_delta_exact_r2: assert (SW'(sample + SW'(chip_avg)) == SW'(core_temp));
  end
endmodule

// File: rtl/tp_hist_window.sv
module tp_hist_window #(
  parameter int SW    = 17,
  parameter int DEPTH = 10,
  parameter int SUMW  = SW + $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stb,
  input  logic                   restart,
  input  logic signed [SW-1:0]   sample_in,
  output logic signed [SUMW-1:0] sum_out,
  output logic signed [SW-1:0]   prev_out,
  output logic                   full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic signed [SW-1:0]   ring [DEPTH];
  logic [PW-1:0]          wr_ptr;
  logic [CW-1:0]          cnt_q;
  logic signed [SUMW-1:0] sum_q;
  logic signed [SW-1:0]   prev_q;
  logic signed [SUMW-1:0] leaving;

  assign full    = (cnt_q == CW'(DEPTH));
  assign leaving = full ? SUMW'(ring[wr_ptr]) : '0;
  assign sum_out = sum_q;
  assign prev_out = prev_q;

  always_ff @(posedge clk) begin
    if (stb) ring[wr_ptr] <= sample_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
      prev_q <= '0;
    end else if (stb) begin
      wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      prev_q <= sample_in;
      if (restart) begin
        sum_q <= SUMW'(sample_in);
        cnt_q <= CW'(1);
      end else begin
        sum_q <= sum_q + SUMW'(sample_in) - leaving;
        if (!full) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R7: fill level only climbs by one or restarts at one
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == CW'(1))));

  // R4: an empty window carries no sum
  p_sum_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (sum_q == '0));
endmodule

// File: rtl/tp_combine.sv
module tp_combine
  import thermpred_pkg::*;
#(
  parameter int SW          = 17,
  parameter int DEPTH       = 10,
  parameter int SUMW        = SW + $clog2(DEPTH + 1),
  parameter int OW          = SW + 3,
  parameter int SLOPE_SHIFT = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic signed [SW-1:0]   x,
  input  logic signed [SW-1:0]   prev,
  input  logic signed [SUMW-1:0] wsum,
  input  logic signed [SW-2:0]   bias,
  output logic signed [OW-1:0]   pred,
  output logic                   pred_vld
);
  localparam int     SH   = SUMW + 2;
  localparam int     PRW  = SUMW + SH + 2;
  localparam longint MULT = recip_mult(DEPTH, SH);
  localparam logic signed [PRW-1:0] NDEP = PRW'(DEPTH);

  logic signed [SUMW-1:0] mean;
  logic signed [SW:0]     slope;
  logic signed [OW-1:0]   pred_q;
  logic                   vld_q;

  function automatic logic signed [SUMW-1:0] floor_mean(input logic signed [SUMW-1:0] s);
    logic signed [PRW-1:0]  prod;
    logic signed [SUMW-1:0] q;
    prod = PRW'(s) * PRW'(MULT);
    q    = SUMW'(prod >>> SH);
    if (PRW'(q) * NDEP > PRW'(s))
      q = q - SUMW'(1);
    else if ((PRW'(q) + PRW'(1)) * NDEP <= PRW'(s))
      q = q + SUMW'(1);
    return q;
  endfunction

  function automatic logic signed [SW:0] slope_of(input logic signed [SW-1:0] cur,
                                                  input logic signed [SW-1:0] old);
    logic signed [SW:0] d;
    d = (SW + 1)'(cur) - (SW + 1)'(old);
    return d >>> SLOPE_SHIFT;
  endfunction

  assign mean  = floor_mean(wsum);
  assign slope = slope_of(x, prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= go;
      if (go) pred_q <= OW'(x) + OW'(mean) - OW'(bias) + OW'(slope);
    end
  end

  assign pred     = pred_q;
  assign pred_vld = vld_q;

  always_comb begin
    if (rst_n) begin
      // R5: mean is the floor of the window sum over DEPTH
      p_mean_floor_r5: assert ((PRW'(mean) * NDEP <= PRW'(wsum)) &&
                               (PRW'(wsum) < (PRW'(mean) + PRW'(1)) * NDEP));
      // R6: slope is the floor of the difference over 2^SLOPE_SHIFT
      p_slope_floor_r6: assert (((SW + 2)'(slope) <<< SLOPE_SHIFT) <= ((SW + 2)'(x) - (SW + 2)'(prev)) &&
                                ((SW + 2)'(x) - (SW + 2)'(prev)) < (((SW + 2)'(slope) + (SW + 2)'(1)) <<< SLOPE_SHIFT));
    end
  end
endmodule

// File: rtl/thermal_trend_predictor.sv
module thermal_trend_predictor #(
  parameter int W           = 16,
  parameter int DEPTH       = 10,
  parameter int SLOPE_SHIFT = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_stb,
  input  logic                  bal_mode,
  input  logic signed [W-1:0]   core_temp,
  input  logic signed [W-1:0]   chip_avg,
  input  logic signed [W-1:0]   hist_bias,
  output logic signed [W+3:0]   pred,
  output logic                  pred_vld,
  output logic                  not_ready
);
  localparam int SW   = W + 1;
  localparam int SUMW = SW + $clog2(DEPTH + 1);
  localparam int OW   = SW + 3;

  logic signed [SW-1:0]   sample;
  logic                   restart;
  logic signed [SUMW-1:0] win_sum;
  logic signed [SW-1:0]   win_prev;
  logic                   win_full;

  logic signed [SW-1:0]   x_s1, prev_s1;
  logic signed [SUMW-1:0] sum_s1;
  logic signed [W-1:0]    bias_s1;
  logic                   go_s1;

  tp_sample_select #(.W(W), .SW(SW)) u_sel (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb), .mode(bal_mode),
    .core_temp(core_temp), .chip_avg(chip_avg),
    .sample(sample), .restart(restart)
  );

  tp_hist_window #(.SW(SW), .DEPTH(DEPTH), .SUMW(SUMW)) u_win (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb), .restart(restart),
    .sample_in(sample), .sum_out(win_sum), .prev_out(win_prev), .full(win_full)
  );

  // stage 1: freeze the pre-update window next to the new sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_s1    <= '0;
      prev_s1 <= '0;
      sum_s1  <= '0;
      bias_s1 <= '0;
      go_s1   <= 1'b0;
    end else begin
      go_s1 <= smp_stb && win_full && !restart;
      if (smp_stb) begin
        x_s1    <= sample;
        prev_s1 <= win_prev;
        sum_s1  <= win_sum;
        bias_s1 <= hist_bias;
      end
    end
  end

  tp_combine #(.SW(SW), .DEPTH(DEPTH), .SUMW(SUMW), .OW(OW), .SLOPE_SHIFT(SLOPE_SHIFT)) u_cmb (
    .clk(clk), .rst_n(rst_n), .go(go_s1), .x(x_s1), .prev(prev_s1),
    .wsum(sum_s1), .bias(bias_s1), .pred(pred), .pred_vld(pred_vld)
  );

  assign not_ready = !win_full;

  // R8: a pulse always traces back to a strobe two cycles earlier
  p_vld_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> $past(smp_stb, 2));

  // R8: output value moves only with the pulse
  p_pred_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_vld |-> $stable(pred));

  // R7: no pulse unless the window was full at the strobe
  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> !$past(not_ready, 2));

  generate
    if (DEPTH > 1) begin : g_restart_chk
      // R9: a mode change empties the window
      p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> not_ready);
    end
  endgenerate
endmodule

// File: tb/tb_thermal_trend_predictor.sv
module tb_thermal_trend_predictor;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic bal_mode = 1'b0;
  logic signed [15:0] core_temp = '0;
  logic signed [15:0] chip_avg = '0;
  logic signed [15:0] hist_bias = '0;
  logic signed [19:0] pred;
  logic pred_vld, not_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int hist[$];
  bit seen = 1'b0;
  bit mode_prev = 1'b0;
  int held = 0;
  int unsigned rng = 32'h2c9e_7a51;

  always #4 clk = ~clk;

  thermal_trend_predictor dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bal_mode(bal_mode),
    .core_temp(core_temp), .chip_avg(chip_avg), .hist_bias(hist_bias),
    .pred(pred), .pred_vld(pred_vld), .not_ready(not_ready)
  );

  function automatic int fdiv(input int a, input int b);
    int q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int rnd16();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return int'($signed(rng[15:0]));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_strobe(input bit m, input int t, input int a, input int h, input string tag);
    int  x, sum, exp;
    bit  vexp, rs;
    x  = m ? (t - a) : t;
    rs = seen && (m != mode_prev);
    if (rs) hist.delete();
    vexp = (hist.size() == N);
    exp  = 0;
    if (vexp) begin
      sum = 0;
      foreach (hist[i]) sum += hist[i];
      exp = x + fdiv(sum, N) - h + fdiv(x - hist[N-1], 2);
    end
    bal_mode  = m;
    core_temp = 16'(t);
    chip_avg  = 16'(a);
    hist_bias = 16'(h);
    smp_stb   = 1'b1;
    @(negedge clk);
    smp_stb   = 1'b0;
    @(negedge clk);
    chk(rs ? "R9 R7 R8 pred_vld" : "R7 R8 pred_vld", int'(pred_vld), int'(vexp));
    if (vexp) begin
      chk(tag, int'(pred), exp);
      held = exp;
    end
    hist.push_back(x);
    if (hist.size() > N) void'(hist.pop_front());
    seen = 1'b1;
    mode_prev = m;
    chk(rs ? "R9 not_ready" : "R7 not_ready", int'(not_ready), int'(hist.size() < N));
    @(negedge clk);
    chk("R8 pulse width", int'(pred_vld), 0);
    chk("R8 pred hold", int'(pred), held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pred_vld", int'(pred_vld), 0);
    chk("R1 not_ready", int'(not_ready), 1);
    chk("R1 pred", int'(pred), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 not_ready after release", int'(not_ready), 1);

    // window fill in absolute mode
    for (int i = 0; i < N; i++) do_strobe(1'b0, 16'h2000 + i * 37, 0, 16'h2600, "R3 fill");

    // constant sample, bias swept around it: mean above bias raises the estimate
    for (int i = 0; i < 14; i++) do_strobe(1'b0, 16'h2600, 0, 16'h2600 + (i - 7) * 64, "R3 bias sweep");

    // pseudo-random signed samples and biases
    for (int i = 0; i < 60; i++) do_strobe(1'b0, rnd16(), 0, rnd16(), "R3 R5 R6 random abs");

    // a single spike must leave the window after N strobes
    do_strobe(1'b0, 16'h7fff, 0, 0, "R4 spike in");
    for (int i = 0; i < N + 2; i++) do_strobe(1'b0, 16'h0100 - i, 0, 0, "R4 spike out");

    // switch to balance mode: restart, refill, random and extreme differences
    do_strobe(1'b1, 16'h2800, 16'h2400, 0, "R9 restart");
    for (int i = 0; i < N + 40; i++) begin
      if (i % 7 == 3)      do_strobe(1'b1, 32767, -32768, rnd16(), "R2 R3 extreme pos");
      else if (i % 7 == 5) do_strobe(1'b1, -32768, 32767, rnd16(), "R2 R3 extreme neg");
      else                 do_strobe(1'b1, rnd16(), rnd16(), rnd16(), "R2 R3 R5 R6 random bal");
    end

    // back to absolute mode: second restart
    for (int i = 0; i < N + 4; i++) do_strobe(1'b0, -1000 + i * 301, 0, -500, "R9 R3 after restart");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule